// File: doc/BRIEF.md
# Stepped Wiper Position Controller

This block is the digital side of a 100-position stepped resistor divider. A host drives three slow pins: an active-low select, a step strobe and a direction level. Each falling edge of the strobe while the block is selected moves the wiper one tap up or down. The position is held in a saturating counter that never leaves the range 0 to 99. That count is decoded into a one-hot enable for the 100 tap switches of the analog array.

The host can save the current position. It does so by releasing the select line while the strobe is held high. The save goes to a register that models a nonvolatile cell. That register survives the block reset and takes a fixed number of clock cycles to write, and during the write the block reports busy. On every reset the counter reloads from the saved value. A part that has never been written comes up at tap 0. A separate erase input returns the nonvolatile model to its never-written state, which models a factory-fresh part.

All three host pins are asynchronous to the clock. They pass through a multi-stage synchronizer before any edge is detected.

Top module: `wiper_ctrl`

## Requirements
- R1: After rst_n is released, wiper_pos takes the saved position within three clock cycles, or 0 if nothing has been saved since the last blank_n assertion.
- R2: A falling edge of inc while cs_n is low and up_dn is 1 raises wiper_pos by exactly one.
- R3: A falling edge of inc while cs_n is low and up_dn is 0 lowers wiper_pos by exactly one.
- R4: wiper_pos never exceeds 99 and never wraps. A step up at 99 leaves it at 99, and a step down at 0 leaves it at 0.
- R5: While cs_n is high, edges on inc leave wiper_pos unchanged.
- R6: tap_sel has exactly one bit set, and that bit is at index wiper_pos (bit 0 means tap 0).
- R7: A rising edge of cs_n while inc is high starts a save of the current position. busy is high for STORE_CYCLES cycles, and a later reset recalls that position.
- R8: A rising edge of cs_n while inc is low saves nothing. A later reset recalls the previously saved value.
- R9: While busy is high, falling edges of inc do not move wiper_pos, even with cs_n low.
- R10: Holding blank_n low clears the saved value, so that the next reset brings wiper_pos to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control logic (saved value kept) |
| blank_n | input | 1 | Asynchronous active-low erase of the nonvolatile model |
| cs_n | input | 1 | Active-low select, asynchronous |
| inc | input | 1 | Step strobe; the wiper steps on its falling edge |
| up_dn | input | 1 | Direction: 1 moves up, 0 moves down |
| tap_sel | output | 100 | One-hot tap switch enable |
| wiper_pos | output | 7 | Current wiper position, 0 to 99 |
| busy | output | 1 | High while a save is being written |

## Verification
The hardest case to reach from the ports is a step strobe that arrives while a save is still being written. The select must first rise with the strobe high. It must then be lowered again, and the strobe must fall, all inside the busy window. The stimulus holds the strobe high across the select release. It re-selects at once and drops the strobe while busy is still reported, so the ignored step is observed before the write completes. Saved values can only be read back through a reset, so each save or non-save is followed by a reset and a check of the recalled position.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

  localparam int unsigned WIPER_TAPS_DEF  = 100;
  localparam int unsigned WIPER_STORE_DEF = 32;

  // Saturating single step inside 0..last.
  function automatic int unsigned wiper_next(int unsigned cur, logic up, int unsigned last);
    if (up) begin
      return (cur >= last) ? last : cur + 1;
    end
    return (cur == 0) ? 0 : cur - 1;
  endfunction

  // Value recalled from the nonvolatile model.
  function automatic int unsigned wiper_recall(logic valid, int unsigned saved);
    return valid ? saved : 0;
  endfunction

endpackage

// File: rtl/wiper_sync.sv
module wiper_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/wiper_counter.sv
module wiper_counter
  import wiper_pkg::*;
#(
  parameter int unsigned NUM_TAPS = WIPER_TAPS_DEF,
  localparam int unsigned POS_W   = $clog2(NUM_TAPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [POS_W-1:0] load_val,
  input  logic             step,
  input  logic             up,
  output logic [POS_W-1:0] pos
);

  localparam int unsigned LAST = NUM_TAPS - 1;

  logic [POS_W-1:0] stepped;

  always_comb begin
    stepped = POS_W'(wiper_next(32'(pos), up, LAST));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos <= '0;
    end else if (load) begin
      pos <= load_val;
    end else if (step) begin
      pos <= stepped;
    end
  end

endmodule

// File: rtl/wiper_decoder.sv
module wiper_decoder #(
  parameter int unsigned NUM_TAPS = 100,
  localparam int unsigned POS_W   = $clog2(NUM_TAPS)
) (
  input  logic [POS_W-1:0]    pos,
  output logic [NUM_TAPS-1:0] sel
);

  for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
    assign sel[i] = (pos == POS_W'(i));
  end

endmodule

// File: rtl/wiper_nvstore.sv
module wiper_nvstore
  import wiper_pkg::*;
#(
  parameter int unsigned NUM_TAPS     = WIPER_TAPS_DEF,
  parameter int unsigned STORE_CYCLES = WIPER_STORE_DEF,
  localparam int unsigned POS_W       = $clog2(NUM_TAPS),
  localparam int unsigned CNT_W       = $clog2(STORE_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blank_n,
  input  logic             store,
  input  logic [POS_W-1:0] pos,
  output logic             busy,
  output logic [POS_W-1:0] recall_val
);

  logic [CNT_W-1:0] wait_cnt;
  logic [POS_W-1:0] pend_val;
  logic [POS_W-1:0] nv_val;
  logic             nv_valid;
  logic             commit;

  assign busy   = (wait_cnt != '0);
  assign commit = (wait_cnt == CNT_W'(1));

  // Write sequencer: restarted by every reset, so a power loss aborts a write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_cnt <= '0;
      pend_val <= '0;
    end else if (store && !busy) begin
      wait_cnt <= CNT_W'(STORE_CYCLES);
      pend_val <= pos;
    end else if (busy) begin
      wait_cnt <= wait_cnt - CNT_W'(1);
    end
  end

  // Nonvolatile model: only the erase input clears it.
  always_ff @(posedge clk or negedge blank_n) begin
    if (!blank_n) begin
      nv_val   <= '0;
      nv_valid <= 1'b0;
    end else if (commit && rst_n) begin
      nv_val   <= pend_val;
      nv_valid <= 1'b1;
    end
  end

  assign recall_val = POS_W'(wiper_recall(nv_valid, 32'(nv_val)));

endmodule

// File: rtl/wiper_ctrl.sv
module wiper_ctrl
  import wiper_pkg::*;
#(
  parameter int unsigned NUM_TAPS     = WIPER_TAPS_DEF,
  parameter int unsigned STORE_CYCLES = WIPER_STORE_DEF,
  parameter int unsigned SYNC_STAGES  = 2,
  localparam int unsigned POS_W       = $clog2(NUM_TAPS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                blank_n,
  input  logic                cs_n,
  input  logic                inc,
  input  logic                up_dn,
  output logic [NUM_TAPS-1:0] tap_sel,
  output logic [POS_W-1:0]    wiper_pos,
  output logic                busy
);

  logic [2:0]       pins_s;
  logic             s_cs_n, s_inc, s_up;
  logic             cs_q, inc_q;
  logic             recall_done;
  logic             inc_fall, cs_rise;
  logic             step_ev, store_ev, recall_ev;
  logic [POS_W-1:0] recall_val;

  wiper_sync #(
    .W       (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b001)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({up_dn, inc, cs_n}),
    .q     (pins_s)
  );

  assign s_cs_n = pins_s[0];
  assign s_inc  = pins_s[1];
  assign s_up   = pins_s[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q        <= 1'b1;
      inc_q       <= 1'b0;
      recall_done <= 1'b0;
    end else begin
      cs_q        <= s_cs_n;
      inc_q       <= s_inc;
      recall_done <= 1'b1;
    end
  end

  assign inc_fall  = inc_q & ~s_inc;
  assign cs_rise   = ~cs_q & s_cs_n;
  assign recall_ev = ~recall_done;
  assign step_ev   = inc_fall & ~s_cs_n & ~busy;
  assign store_ev  = cs_rise & s_inc & ~busy;

  wiper_counter #(.NUM_TAPS(NUM_TAPS)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (recall_ev),
    .load_val (recall_val),
    .step     (step_ev),
    .up       (s_up),
    .pos      (wiper_pos)
  );

  wiper_decoder #(.NUM_TAPS(NUM_TAPS)) u_dec (
    .pos (wiper_pos),
    .sel (tap_sel)
  );

  wiper_nvstore #(
    .NUM_TAPS     (NUM_TAPS),
    .STORE_CYCLES (STORE_CYCLES)
  ) u_nv (
    .clk        (clk),
    .rst_n      (rst_n),
    .blank_n    (blank_n),
    .store      (store_ev),
    .pos        (wiper_pos),
    .busy       (busy),
    .recall_val (recall_val)
  );

endmodule

// File: rtl/wiper_ctrl_chk.sv
module wiper_ctrl_chk #(
  parameter int unsigned NUM_TAPS = 100,
  localparam int unsigned POS_W   = $clog2(NUM_TAPS)
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_TAPS-1:0] tap_sel,
  input logic [POS_W-1:0]    wiper_pos,
  input logic                busy,
  input logic                step_ev,
  input logic                step_up,
  input logic                store_ev,
  input logic                recall_ev
);

  localparam logic [POS_W-1:0] LAST = POS_W'(NUM_TAPS - 1);

  // R4
  range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wiper_pos <= LAST);

  // R6
  onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(tap_sel) == 1) && tap_sel[wiper_pos]);

  // R2
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ev && step_up && !recall_ev && wiper_pos < LAST) |=> wiper_pos == $past(wiper_pos) + POS_W'(1));

  // R3
  step_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ev && !step_up && !recall_ev && wiper_pos != '0) |=> wiper_pos == $past(wiper_pos) - POS_W'(1));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_ev && !recall_ev) |=> $stable(wiper_pos));

  // R7
  store_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_ev |=> busy);

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !recall_ev) |=> $stable(wiper_pos));

endmodule

bind wiper_ctrl wiper_ctrl_chk #(.NUM_TAPS(NUM_TAPS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tap_sel   (tap_sel),
  .wiper_pos (wiper_pos),
  .busy      (busy),
  .step_ev   (step_ev),
  .step_up   (s_up),
  .store_ev  (store_ev),
  .recall_ev (recall_ev)
);

// File: tb/test_wiper_ctrl.sv
module test_wiper_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int TAPS       = 100;
  localparam int STORE      = 40;
  localparam int WATCHDOG   = 150000;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            blank_n = 1'b0;
  logic            cs_n = 1'b1;
  logic            inc = 1'b0;
  logic            up_dn = 1'b0;
  logic [TAPS-1:0] tap_sel;
  logic [6:0]      wiper_pos;
  logic            busy;

  int checks = 0;
  int errors = 0;
  int exp_pos = 0;
  int saved   = 0;
  bit saved_ok = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wiper_ctrl #(.NUM_TAPS(TAPS), .STORE_CYCLES(STORE)) i_wiper_ctrl (
    .clk(clk), .rst_n(rst_n), .blank_n(blank_n), .cs_n(cs_n), .inc(inc),
    .up_dn(up_dn), .tap_sel(tap_sel), .wiper_pos(wiper_pos), .busy(busy)
  );

  function automatic int model_step(int p, bit up);
    if (up) return (p == TAPS - 1) ? p : p + 1;
    return (p == 0) ? 0 : p - 1;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_taps(string tag);
    logic [TAPS-1:0] want;
    want = '0;
    want[exp_pos] = 1'b1;
    checks++;
    if (tap_sel !== want) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, tap_sel, want);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse();
    inc = 1'b1; cyc(4);
    inc = 1'b0; cyc(4);
  endtask

  task automatic do_reset(string tag);
    rst_n = 1'b0; cyc(2);
    rst_n = 1'b1; cyc(4);
    exp_pos = saved_ok ? saved : 0;
    chk(tag, wiper_pos, exp_pos);
  endtask

  initial begin
    cyc(3);
    blank_n = 1'b1;
    cyc(1);
    // R1: blank part recalls 0
    do_reset("R1 blank recall");
    chk_taps("R6 after reset");
    chk("R7 idle busy", busy, 0);
    cs_n = 1'b0; cyc(4);

    // R2 / R4: drive to the top end
    up_dn = 1'b1; cyc(2);
    for (int i = 0; i < 105; i++) begin
      pulse();
      exp_pos = model_step(exp_pos, 1'b1);
      if (i == 0) chk("R2 single up", wiper_pos, 1);
    end
    chk("R4 saturate at 99", wiper_pos, 99);
    chk_taps("R6 at 99");

    // R3 / R4: drive to the bottom end
    up_dn = 1'b0; cyc(2);
    for (int i = 0; i < 105; i++) begin
      pulse();
      exp_pos = model_step(exp_pos, 1'b0);
      if (i == 0) chk("R3 single down", wiper_pos, 98);
    end
    chk("R4 saturate at 0", wiper_pos, 0);
    chk_taps("R6 at 0");

    // Random mix of steps and deselected strobes
    void'($urandom(32'd1234));
    for (int i = 0; i < 400; i++) begin
      bit up;
      up = 1'($urandom_range(0, 3) != 0);
      up_dn = up; cyc(2);
      if ($urandom_range(0, 9) == 0) begin
        cs_n = 1'b1; cyc(4);
        pulse();
        chk("R5 deselected strobe", wiper_pos, exp_pos);
        cs_n = 1'b0; cyc(4);
      end else begin
        pulse();
        exp_pos = model_step(exp_pos, up);
        chk(up ? "R2 random up" : "R3 random down", wiper_pos, exp_pos);
        chk_taps("R6 random");
      end
    end

    // R7 / R9: save, then strobe during busy
    inc = 1'b1; cyc(4);
    cs_n = 1'b1; cyc(4);
    chk("R7 busy after save", busy, 1);
    saved = exp_pos; saved_ok = 1;
    cs_n = 1'b0; cyc(4);
    inc = 1'b0; cyc(4);
    chk("R9 busy still high", busy, 1);
    chk("R9 strobe ignored while busy", wiper_pos, exp_pos);
    cyc(STORE);
    chk("R7 busy cleared", busy, 0);
    do_reset("R7 recall saved");

    // R8: move, deselect without save, reset
    cs_n = 1'b0; up_dn = (saved < 50); cyc(4);
    for (int i = 0; i < 5; i++) begin
      pulse();
      exp_pos = model_step(exp_pos, up_dn);
    end
    chk("R8 moved", wiper_pos, exp_pos);
    cs_n = 1'b1; cyc(6);
    chk("R8 no busy", busy, 0);
    do_reset("R8 old value recalled");

    // R10: erase then reset
    blank_n = 1'b0; cyc(2); blank_n = 1'b1; cyc(1);
    saved_ok = 0;
    do_reset("R10 erased recall");
    chk_taps("R6 after erase");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule